// File: doc/BRIEF.md
# Start-up Sequencer and Output Supervisor

This block brings a single-phase step-down converter out of power-on and then watches its sensed output. It qualifies the bias supply with hysteresis. It waits for the external overcurrent threshold capture to finish. It then ramps a digital reference code linearly from zero to its final value. When the ramp completes, it arms the under-voltage check and raises power-good. The error amplifier and the PWM comparator are outside this block. They consume the reference code and obey the gate override that this block issues.

All analog quantities arrive as 10-bit codes. The supply code has an LSB of 20 mV. The sensed output and the compensation-pin codes have an LSB of 1 mV. Protection faults are sticky and clear only when the supply drops out. The over-voltage fault keeps steering the low-side switch from the sensed output after it has latched.

Top module: `startup_supervisor`

## Requirements
- R1: Supply-OK sets when `supplyCode` > 205 (4.1 V at 20 mV/LSB) and clears when `supplyCode` < 195. Codes from 195 to 205 keep the previous state. While supply-OK is clear, the block holds `refCode`=0, `ssDone`=0 and `gateOvr`=2'b01.
- R2: The ramp starts only when supply-OK is set, `ocSetDone` is 1 and the converter is enabled. Until then `refCode` stays 0 and `gateOvr`=2'b01.
- R3: During soft-start, `refCode` rises by one code every STEP_CYC clocks, where STEP_CYC = CLK_KHZ*RAMP_US/(1000*800) with a minimum of 1. It stops at 800 (0.8 V), and `ssDone` rises on the clock after the code reaches 800.
- R4: An under-voltage reading (`senseCode` < 600) during soft-start has no effect. The under-voltage check is armed only once `ssDone` is 1.
- R5: `pwrGood` is 1 only while `ssDone` is 1, no fault is latched and 710 ≤ `senseCode` ≤ 890. Leaving that window clears `pwrGood` while `gateOvr` stays 2'b00.
- R6: An under-voltage reading after soft-start latches a fault that drives `gateOvr`=2'b01 (both gates off) and clears `pwrGood`. The fault stays latched after the output recovers.
- R7: `senseCode` > 1000 latches an over-voltage fault in any state with supply-OK, soft-start included. While this fault is latched, `gateOvr` is 2'b10 (high side off, low side on) when `senseCode` > 400 and 2'b01 otherwise. This holds whatever the output later does.
- R8: `lsBlank` is 1 during soft-start until `hsSwitched` is first seen high. `lsBlank` is always 0 once soft-start has ended, even if the high side never switched.
- R9: `compCode` < 750 disables the converter. The block then sets `gateOvr`=2'b01, returns `refCode` to 0 and clears `ssDone`. Raising `compCode` again starts a fresh ramp.
- R10: Latched faults clear only when supply-OK clears. The sequence then restarts from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyCode | input | 10 | Bias supply code, 20 mV/LSB |
| senseCode | input | 10 | Sensed output code, 1 mV/LSB |
| compCode | input | 10 | Compensation pin code, 1 mV/LSB |
| ocSetDone | input | 1 | Overcurrent threshold capture finished |
| hsSwitched | input | 1 | High-side gate has switched in this cycle |
| refCode | output | 10 | Reference code to the error amplifier |
| ssDone | output | 1 | Soft-start complete |
| pwrGood | output | 1 | Output within window after soft-start |
| lsBlank | output | 1 | Low-side switching blanked for pre-biased start-up |
| gateOvr | output | 2 | Gate override: 00 none, 01 both off, 10 high off / low on |

## Verification
The bench builds the block with CLK_KHZ=50000 and RAMP_US=32. This gives two clocks per reference step, so a full ramp takes 1600 clocks instead of roughly 225,000. That makes it practical to check the exact mid-ramp code, the last code before `ssDone`, and several complete restarts after supply cycling and disable. All voltage thresholds keep their default codes, so every window edge and fault level is exercised at its real value.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    OVR_NONE    = 2'b00,
    OVR_ALL_OFF = 2'b01,
    OVR_LS_ON   = 2'b10
  } gate_ovr_e;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_WAIT,
    ST_RAMP,
    ST_RUN
  } seq_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic rampClr;
    logic rampEn;
  } ramp_ctl_t;

  // registered monitor flags from datapath to control
  typedef struct packed {
    logic supplyOk;
    logic disabled;
    logic overV;
    logic underV;
    logic aboveRel;
    logic inWindow;
    logic rampTop;
  } mon_flags_t;

endpackage

// File: rtl/sup_datapath.sv
module sup_datapath
  import sup_pkg::*;
#(
  parameter int unsigned CODE_W    = 10,
  parameter int unsigned STEP_CYC  = 281,
  parameter int unsigned REF_FINAL = 800,
  parameter int unsigned SUP_ON    = 205,
  parameter int unsigned SUP_OFF   = 195,
  parameter int unsigned DIS_TH    = 750,
  parameter int unsigned OV_TH     = 1000,
  parameter int unsigned OV_REL    = 400,
  parameter int unsigned UV_TH     = 600,
  parameter int unsigned PG_LO     = 710,
  parameter int unsigned PG_HI     = 890
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] supplyCode,
  input  logic [CODE_W-1:0] senseCode,
  input  logic [CODE_W-1:0] compCode,
  input  ramp_ctl_t         ctl,
  output mon_flags_t        flags,
  output logic [CODE_W-1:0] refCode
);

  localparam logic [CODE_W-1:0] SupOnC  = CODE_W'(SUP_ON);
  localparam logic [CODE_W-1:0] SupOffC = CODE_W'(SUP_OFF);
  localparam logic [CODE_W-1:0] DisC    = CODE_W'(DIS_TH);
  localparam logic [CODE_W-1:0] OvC     = CODE_W'(OV_TH);
  localparam logic [CODE_W-1:0] RelC    = CODE_W'(OV_REL);
  localparam logic [CODE_W-1:0] UvC     = CODE_W'(UV_TH);
  localparam logic [CODE_W-1:0] PgLoC   = CODE_W'(PG_LO);
  localparam logic [CODE_W-1:0] PgHiC   = CODE_W'(PG_HI);
  localparam logic [CODE_W-1:0] RefFinC = CODE_W'(REF_FINAL);

  logic              supplyOk, disabledQ, ovQ, uvQ, relQ, winQ;
  logic [CODE_W-1:0] refQ;
  logic              tick;

  // supply qualification with hysteresis, other comparisons registered once
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      supplyOk  <= 1'b0;
      disabledQ <= 1'b1;
      ovQ       <= 1'b0;
      uvQ       <= 1'b0;
      relQ      <= 1'b0;
      winQ      <= 1'b0;
    end else begin
      if (supplyCode > SupOnC)       supplyOk <= 1'b1;
      else if (supplyCode < SupOffC) supplyOk <= 1'b0;
      disabledQ <= (compCode < DisC);
      ovQ       <= (senseCode > OvC);
      uvQ       <= (senseCode < UvC);
      relQ      <= (senseCode > RelC);
      winQ      <= (senseCode >= PgLoC) && (senseCode <= PgHiC);
    end
  end

  // step divider: a variant without counter when every clock is a step
  generate
    if (STEP_CYC > 1) begin : g_div
      localparam int unsigned CNT_W = $clog2(STEP_CYC);
      localparam logic [CNT_W-1:0] CntLast = CNT_W'(STEP_CYC - 1);
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            cnt <= '0;
        else if (ctl.rampClr) cnt <= '0;
        else if (ctl.rampEn)  cnt <= (cnt == CntLast) ? '0 : cnt + 1'b1;
      end
      assign tick = ctl.rampEn && (cnt == CntLast);
    end else begin : g_nodiv
      assign tick = ctl.rampEn;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        refQ <= '0;
    else if (ctl.rampClr)             refQ <= '0;
    else if (tick && refQ != RefFinC) refQ <= refQ + 1'b1;
  end

  assign refCode = refQ;
  assign flags = '{supplyOk: supplyOk, disabled: disabledQ, overV: ovQ,
                   underV: uvQ, aboveRel: relQ, inWindow: winQ,
                   rampTop: (refQ == RefFinC)};

  AST_REF_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    refQ <= RefFinC); // R3
  AST_REF_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.rampClr |=> (refQ == $past(refQ)) || (refQ == $past(refQ) + 1'b1)); // R3
  AST_SUP_HYST: assert property (@(posedge clk) disable iff (!rstN)
    supplyOk && (supplyCode >= SupOffC) |=> supplyOk); // R1

endmodule

// File: rtl/sup_control.sv
module sup_control
  import sup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  mon_flags_t flags,
  input  logic       ocSetDone,
  input  logic       hsSwitched,
  output ramp_ctl_t  ctl,
  output logic       ssDone,
  output logic       pwrGood,
  output logic       lsBlank,
  output gate_ovr_e  gateOvr
);

  seq_state_e state;
  logic       uvLatch, ovLatch, hsSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_OFF;
      uvLatch <= 1'b0;
      ovLatch <= 1'b0;
      hsSeen  <= 1'b0;
    end else if (!flags.supplyOk) begin
      state   <= ST_OFF;
      uvLatch <= 1'b0;
      ovLatch <= 1'b0;
      hsSeen  <= 1'b0;
    end else begin
      unique case (state)
        ST_OFF:  state <= ST_WAIT;
        ST_WAIT: if (ocSetDone && !flags.disabled) state <= ST_RAMP;
        ST_RAMP: begin
          if (flags.disabled)     state <= ST_WAIT;
          else if (flags.rampTop) state <= ST_RUN;
        end
        ST_RUN:  if (flags.disabled) state <= ST_WAIT;
        default: state <= ST_OFF;
      endcase
      if (flags.overV) ovLatch <= 1'b1;
      if (flags.underV && state == ST_RUN && !ovLatch) uvLatch <= 1'b1;
      if (state == ST_RAMP) begin
        if (hsSwitched) hsSeen <= 1'b1;
      end else if (state != ST_RUN) begin
        hsSeen <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl.rampClr = (state == ST_OFF) || (state == ST_WAIT);
    ctl.rampEn  = (state == ST_RAMP);
  end

  always_comb begin
    if (ovLatch)      gateOvr = flags.aboveRel ? OVR_LS_ON : OVR_ALL_OFF;
    else if (uvLatch) gateOvr = OVR_ALL_OFF;
    else if (ctl.rampClr) gateOvr = OVR_ALL_OFF;
    else              gateOvr = OVR_NONE;
  end

  assign ssDone  = (state == ST_RUN);
  assign pwrGood = ssDone && flags.inWindow && !uvLatch && !ovLatch;
  assign lsBlank = (state == ST_RAMP) && !hsSeen;

  AST_UV_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(uvLatch) |-> $past(state) == ST_RUN); // R4
  AST_START_GATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.rampEn) |-> $past(ocSetDone)); // R2
  AST_OV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ovLatch && flags.supplyOk |=> ovLatch); // R7
  AST_PG_AT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    pwrGood |-> flags.rampTop); // R5
  AST_DIS_STOP: assert property (@(posedge clk) disable iff (!rstN)
    flags.disabled && flags.supplyOk |=> !ssDone); // R9

endmodule

// File: rtl/startup_supervisor.sv
module startup_supervisor
  import sup_pkg::*;
#(
  parameter int unsigned CODE_W    = 10,
  parameter int unsigned CLK_KHZ   = 50000,
  parameter int unsigned RAMP_US   = 4500,
  parameter int unsigned REF_FINAL = 800,
  parameter int unsigned SUP_ON    = 205,
  parameter int unsigned SUP_OFF   = 195,
  parameter int unsigned DIS_TH    = 750,
  parameter int unsigned OV_TH     = 1000,
  parameter int unsigned OV_REL    = 400,
  parameter int unsigned UV_TH     = 600,
  parameter int unsigned PG_LO     = 710,
  parameter int unsigned PG_HI     = 890
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] supplyCode,
  input  logic [CODE_W-1:0] senseCode,
  input  logic [CODE_W-1:0] compCode,
  input  logic              ocSetDone,
  input  logic              hsSwitched,
  output logic [CODE_W-1:0] refCode,
  output logic              ssDone,
  output logic              pwrGood,
  output logic              lsBlank,
  output logic [1:0]        gateOvr
);

  localparam int unsigned StepRaw = (CLK_KHZ * RAMP_US) / (1000 * REF_FINAL);
  localparam int unsigned StepCyc = (StepRaw < 1) ? 1 : StepRaw;

  ramp_ctl_t  ctl;
  mon_flags_t flags;
  gate_ovr_e  ovr;

  sup_datapath #(
    .CODE_W(CODE_W), .STEP_CYC(StepCyc), .REF_FINAL(REF_FINAL),
    .SUP_ON(SUP_ON), .SUP_OFF(SUP_OFF), .DIS_TH(DIS_TH), .OV_TH(OV_TH),
    .OV_REL(OV_REL), .UV_TH(UV_TH), .PG_LO(PG_LO), .PG_HI(PG_HI)
  ) u_dp (
    .clk(clk), .rstN(rstN), .supplyCode(supplyCode), .senseCode(senseCode),
    .compCode(compCode), .ctl(ctl), .flags(flags), .refCode(refCode)
  );

  sup_control u_ctl (
    .clk(clk), .rstN(rstN), .flags(flags), .ocSetDone(ocSetDone),
    .hsSwitched(hsSwitched), .ctl(ctl), .ssDone(ssDone), .pwrGood(pwrGood),
    .lsBlank(lsBlank), .gateOvr(ovr)
  );

  assign gateOvr = ovr;

endmodule

// File: tb/tb_startup_supervisor.sv
module tb_startup_supervisor;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] supplyCode = '0, senseCode = '0, compCode = '0;
  logic       ocSetDone = 1'b0, hsSwitched = 1'b0;
  logic [9:0] refCode;
  logic       ssDone, pwrGood, lsBlank;
  logic [1:0] gateOvr;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk; // 50 MHz

  startup_supervisor #(.CLK_KHZ(50000), .RAMP_US(32)) dut (
    .clk(clk), .rstN(rstN), .supplyCode(supplyCode), .senseCode(senseCode),
    .compCode(compCode), .ocSetDone(ocSetDone), .hsSwitched(hsSwitched),
    .refCode(refCode), .ssDone(ssDone), .pwrGood(pwrGood),
    .lsBlank(lsBlank), .gateOvr(gateOvr)
  );

  typedef struct {
    int         refExp;   // -1: not compared
    bit         ss;
    bit         pg;
    bit         bl;
    logic [1:0] ovr;
    string      tag;
  } exp_t;

  exp_t sb[$];

  function automatic void cmp(string tag, string fld, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, fld, act, exp);
    end
  endfunction

  // monitor: pops expectations and compares at the falling edge
  always @(negedge clk) begin
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      if (e.refExp >= 0) cmp(e.tag, "refCode", int'(refCode), e.refExp);
      cmp(e.tag, "ssDone", int'(ssDone), int'(e.ss));
      cmp(e.tag, "pwrGood", int'(pwrGood), int'(e.pg));
      cmp(e.tag, "lsBlank", int'(lsBlank), int'(e.bl));
      cmp(e.tag, "gateOvr", int'(gateOvr), int'(e.ovr));
    end
  end

  task automatic drive(int sup, int sen, int cp, bit oc);
    @(negedge clk);
    supplyCode = 10'(sup);
    senseCode  = 10'(sen);
    compCode   = 10'(cp);
    ocSetDone  = oc;
  endtask

  task automatic expectAfter(int n, int r, bit s, bit p, bit b,
                             logic [1:0] o, string tag);
    exp_t e;
    repeat (n) @(posedge clk);
    e.refExp = r; e.ss = s; e.pg = p; e.bl = b; e.ovr = o; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    expectAfter(1, 0, 0, 0, 0, 2'b01, "reset state R1");

    // supply inside the hysteresis band from off: stays off (R1)
    drive(200, 0, 900, 1);
    expectAfter(6, 0, 0, 0, 0, 2'b01, "R1 band holds off");
    // supply OK but capture not done: no ramp (R2)
    drive(210, 0, 900, 0);
    expectAfter(6, 0, 0, 0, 0, 2'b01, "R2 waits for ocSetDone");

    // start ramp with output low: UV masked, blank on (R3 R4 R8)
    drive(210, 300, 900, 1);
    expectAfter(1001, 500, 0, 0, 1, 2'b00, "R3 mid ramp R4 R8");
    // supply into the band: stays on (R1)
    drive(200, 750, 900, 1);
    expectAfter(599, 799, 0, 0, 1, 2'b00, "R3 last step R1 band holds on");
    expectAfter(21, 800, 1, 1, 0, 2'b00, "R3 done R5 pg R8 blank removed");

    // power-good window (R5)
    drive(200, 900, 900, 1);
    expectAfter(4, 800, 1, 0, 0, 2'b00, "R5 above window");
    drive(200, 750, 900, 1);
    expectAfter(4, 800, 1, 1, 0, 2'b00, "R5 back in window");

    // under-voltage armed after soft-start (R4 R6)
    drive(200, 550, 900, 1);
    expectAfter(4, 800, 1, 0, 0, 2'b01, "R6 UV trip R4 armed");
    drive(200, 750, 900, 1);
    expectAfter(4, 800, 1, 0, 0, 2'b01, "R6 UV latched");

    // supply cycle clears fault (R10)
    drive(190, 750, 900, 1);
    expectAfter(4, 0, 0, 0, 0, 2'b01, "R10 supply drop");
    drive(210, 750, 900, 1);
    expectAfter(4, -1, 0, 0, 1, 2'b00, "R10 restart R8 blank");

    // high side switches early: blank removed before soft-start end (R8)
    @(negedge clk) hsSwitched = 1'b1;
    @(negedge clk) hsSwitched = 1'b0;
    expectAfter(3, -1, 0, 0, 0, 2'b00, "R8 blank cleared by switching");

    // over-voltage during soft-start (R7)
    drive(210, 1010, 900, 1);
    expectAfter(4, -1, 0, 0, 0, 2'b10, "R7 OV trip in ramp");
    drive(210, 350, 900, 1);
    expectAfter(4, -1, 0, 0, 0, 2'b01, "R7 low side released");
    drive(210, 500, 900, 1);
    expectAfter(4, -1, 0, 0, 0, 2'b10, "R7 low side back on");
    drive(210, 750, 900, 1);
    expectAfter(4, -1, 0, 0, 0, 2'b10, "R7 OV latched");

    // supply cycle clears OV (R10)
    drive(190, 750, 900, 1);
    expectAfter(4, 0, 0, 0, 0, 2'b01, "R10 supply drop OV");
    drive(210, 750, 900, 1);
    expectAfter(4, -1, 0, 0, 1, 2'b00, "R10 OV cleared");

    // disable and re-enable (R9)
    drive(210, 750, 700, 1);
    expectAfter(4, 0, 0, 0, 0, 2'b01, "R9 disabled");
    expectAfter(20, 0, 0, 0, 0, 2'b01, "R9 held at zero");
    drive(210, 750, 900, 1);
    expectAfter(1700, 800, 1, 1, 0, 2'b00, "R9 re-enabled full ramp");

    wait (sb.size() == 0);
    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule